// File: doc/BRIEF.md
# Buffered SPI Master Transmitter

This block is the clock-owning end of a serial peripheral link. It drives SCLK from its own divider and shifts 8-bit characters out on MOSI, most significant bit first, while it collects 8 bits from MISO. Software writes characters into a one-entry holding buffer that sits in front of the shift register. When the shifter finishes a character and the buffer holds the next one, the next character starts with no pause on SCLK.

A sticky transmit-request flag tells software when it may write again. The instant it rises depends on the shifter. If the shifter is empty, the written character goes straight into it and the flag rises in the very next cycle, whatever the divider. If the shifter is busy, the written character waits in the buffer, and the flag rises at the final latching SCLK edge of the character being sent. A receive-complete flag and a receive register carry the incoming character. A clock phase bit and a polarity bit select the SPI mode. Clearing the enable bit parks SCLK and drops any work that is in flight.

Top module: `spi_tx_master`

## Requirements
- R1: After reset the block is disabled, SCLK and MOSI are low, both flags are low, and the control register reads as 0.
- R2: Each SCLK half period lasts max(div, 2) system clocks, where div is control bits 15:8. A character takes 16 half periods, and its first edge comes that many clocks after it is loaded. When idle, SCLK sits at the polarity bit (control bit 2).
- R3: With phase 0 (control bit 1 clear), MOSI shows bit 7 from the moment the character loads and moves to the next bit on edges 2, 4, …, 14. MISO is sampled on edges 1, 3, …, 15.
- R4: With phase 1, MOSI shows bit 7 from the load and moves to the next bit on edges 3, 5, …, 15. MISO is sampled on edges 2, 4, …, 16.
- R5: A write to the data address (1) while enabled and idle starts the character at once, and the transmit-request flag is high in the cycle right after the write.
- R6: A write to the data address while a character is in progress fills the buffer. The flag then rises at the last latching edge of the current character: edge 15 with phase 0, edge 16 with phase 1.
- R7: If the buffer is full when a character ends, the buffered character loads on that same clock. Two characters therefore take exactly 32 half periods.
- R8: The transmit-request flag stays high until a write to address 2 with bit 0 set. Writing address 2 with only bit 1 set leaves it unchanged.
- R9: At edge 16 the received character appears in the receive register (read at address 2, bits 7:0) and the receive-complete flag rises. A write to address 2 with bit 1 set clears that flag.
- R10: While the enable bit (control bit 0) is clear, SCLK stays at its idle level, the shifter and buffer are empty, data writes are dropped and the request flag is never set.
- R11: The read port is combinational. Address 0 returns the control register. Address 1 returns status: bit 0 busy, bit 1 buffer full, bit 2 transmit request, bit 3 receive complete. Address 2 returns the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| tx_req_o | output | 1 | Transmit-request flag |
| rx_done_o | output | 1 | Receive-complete flag |

## Verification
Every result is due at a fixed clock count after its cause. The request flag after an idle write is due one edge later. The request flag for a buffered character is due 15·D clocks after the first load with phase 0, and 16·D clocks with phase 1. The end of a back-to-back pair is due 32·D clocks after the first load. The bench counts clocks from the write edge to check each of these figures. A behavioural model advances on the same clock edges and is compared against SCLK, MOSI, the flags and the read port 3 ns after every edge, so any drift of even one cycle shows up in the cycle it happens.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PHA  = 1;
  localparam int CTRL_POL  = 2;
  localparam int CTRL_DIV  = 8;

  localparam int STAT_BUSY = 0;
  localparam int STAT_FULL = 1;
  localparam int STAT_TXR  = 2;
  localparam int STAT_RXD  = 3;

  localparam int CLR_TXR   = 0;
  localparam int CLR_RXD   = 1;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W  = 8,
  parameter int EDGES  = 16,
  parameter int EDGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tick_o,
  output logic [EDGE_W-1:0] edge_num_o
);
  localparam logic [DIV_W-1:0]  MIN_DIV = DIV_W'(2);
  localparam logic [EDGE_W-1:0] E_CNT   = EDGE_W'(EDGES);

  logic [DIV_W-1:0]  cnt_q, div_eff;
  logic [EDGE_W-1:0] edge_q;

  assign div_eff    = (div_i < MIN_DIV) ? MIN_DIV : div_i;
  assign tick_o     = busy_i && (cnt_q == div_eff - 1'b1);
  assign edge_num_o = edge_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      edge_q <= '0;
    end else if (!en_i || !busy_i || load_i) begin
      cnt_q  <= '0;
      edge_q <= '0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      edge_q <= edge_num_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2
  edge_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (edge_q < E_CNT));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int CHAR_W = 8,
  parameter int EDGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pha_i,
  input  logic              wtx_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              miso_i,
  input  logic              tick_i,
  input  logic [EDGE_W-1:0] edge_num_i,
  output logic              busy_o,
  output logic              buf_full_o,
  output logic              load_o,
  output logic              sclk_st_o,
  output logic              mosi_o,
  output logic              set_req_o,
  output logic              rx_valid_o,
  output logic [CHAR_W-1:0] rx_word_o
);
  localparam int EDGES = 2 * CHAR_W;
  localparam logic [EDGE_W-1:0] E_LAST  = EDGE_W'(EDGES);
  localparam logic [EDGE_W-1:0] E_PRE   = EDGE_W'(EDGES - 1);
  localparam logic [EDGE_W-1:0] E_SHMAX = EDGE_W'(EDGES - 2);
  localparam logic [EDGE_W-1:0] E_SHMIN = EDGE_W'(3);

  logic [CHAR_W-1:0] tx_q, rx_q, buf_q, rx_n;
  logic busy_q, full_q, sig_q, st_q;
  logic odd, lat, shf, fin, last_lat, slot, load_buf, load_dir, buf_wr, sig_now;

  assign odd      = edge_num_i[0];
  assign lat      = tick_i && (pha_i ? !odd : odd);
  assign shf      = tick_i && (pha_i ? (odd && edge_num_i >= E_SHMIN)
                                     : (!odd && edge_num_i <= E_SHMAX));
  assign fin      = tick_i && (edge_num_i == E_LAST);
  assign last_lat = lat && (edge_num_i == (pha_i ? E_LAST : E_PRE));
  assign slot     = !busy_q || fin;
  assign load_buf = en_i && slot && full_q;
  assign load_dir = en_i && slot && !full_q && wtx_i;
  assign buf_wr   = en_i && wtx_i && !load_dir;
  // buffered character announced at last latch of running one
  assign sig_now  = en_i && last_lat && full_q && !slot;
  assign rx_n     = lat ? {rx_q[CHAR_W-2:0], miso_i} : rx_q;

  assign set_req_o  = load_dir || (load_buf && !sig_q) || sig_now;
  assign load_o     = load_buf || load_dir;
  assign rx_valid_o = en_i && fin;
  assign rx_word_o  = rx_n;
  assign busy_o     = busy_q;
  assign buf_full_o = full_q;
  assign sclk_st_o  = st_q;
  assign mosi_o     = busy_q & tx_q[CHAR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; buf_q <= '0;
      busy_q <= 1'b0; full_q <= 1'b0; sig_q <= 1'b0; st_q <= 1'b0;
    end else if (!en_i) begin
      busy_q <= 1'b0; full_q <= 1'b0; sig_q <= 1'b0; st_q <= 1'b0;
    end else begin
      if (tick_i) begin
        st_q <= ~st_q;
        rx_q <= rx_n;
        if (shf) tx_q <= {tx_q[CHAR_W-2:0], 1'b0};
      end
      if (fin) begin
        busy_q <= 1'b0;
        st_q   <= 1'b0;
      end
      if (load_buf) begin
        tx_q <= buf_q; busy_q <= 1'b1; st_q <= 1'b0;
      end else if (load_dir) begin
        tx_q <= wdata_i; busy_q <= 1'b1; st_q <= 1'b0;
      end
      if (buf_wr) begin
        buf_q  <= wdata_i;
        full_q <= 1'b1;
      end else if (load_buf) begin
        full_q <= 1'b0;
      end
      if (buf_wr)        sig_q <= 1'b0;
      else if (sig_now)  sig_q <= 1'b1;
      else if (load_buf) sig_q <= 1'b0;
    end
  end

  // R7
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fin && full_q) |=> busy_o);

  // R10
  disable_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !buf_full_o));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_tx_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [2:0]        ctl_bits_i,
  input  logic [DIV_W-1:0]  div_wr_i,
  input  logic              busy_i,
  input  logic              buf_full_i,
  input  logic              set_req_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_word_i,
  output logic              en_o,
  output logic              pha_o,
  output logic              pol_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              wtx_o,
  output logic              tx_req_o,
  output logic              rx_done_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic en_q, pha_q, pol_q, txr_q, rxd_q, clr_txr, clr_rxd;
  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] rxw_q;

  assign wtx_o   = we_i && (addr_i == ADDR_DATA);
  assign clr_txr = we_i && (addr_i == ADDR_FLAG) && ctl_bits_i[CLR_TXR];
  assign clr_rxd = we_i && (addr_i == ADDR_FLAG) && ctl_bits_i[CLR_RXD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; pha_q <= 1'b0; pol_q <= 1'b0; div_q <= '0;
      txr_q <= 1'b0; rxd_q <= 1'b0; rxw_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_CTRL) begin
        en_q  <= ctl_bits_i[CTRL_EN];
        pha_q <= ctl_bits_i[CTRL_PHA];
        pol_q <= ctl_bits_i[CTRL_POL];
        div_q <= div_wr_i;
      end
      if (set_req_i)    txr_q <= 1'b1;
      else if (clr_txr) txr_q <= 1'b0;
      if (rx_valid_i) begin
        rxd_q <= 1'b1;
        rxw_q <= rx_word_i;
      end else if (clr_rxd) begin
        rxd_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]  = en_q;
        rdata_o[CTRL_PHA] = pha_q;
        rdata_o[CTRL_POL] = pol_q;
        rdata_o[CTRL_DIV +: DIV_W] = div_q;
      end
      ADDR_DATA: begin
        rdata_o[STAT_BUSY] = busy_i;
        rdata_o[STAT_FULL] = buf_full_i;
        rdata_o[STAT_TXR]  = txr_q;
        rdata_o[STAT_RXD]  = rxd_q;
      end
      ADDR_FLAG: rdata_o[CHAR_W-1:0] = rxw_q;
      default:   rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign pha_o     = pha_q;
  assign pol_o     = pol_q;
  assign div_o     = div_q;
  assign tx_req_o  = txr_q;
  assign rx_done_o = rxd_q;

  // R8
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !clr_txr) |=> tx_req_o);

  // R9
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rxd && !rx_valid_i) |=> !rx_done_o);
endmodule

// File: rtl/spi_tx_master.sv
module spi_tx_master #(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             tx_req_o,
  output logic             rx_done_o
);
  localparam int EDGES  = 2 * CHAR_W;
  localparam int EDGE_W = $clog2(EDGES + 1);

  logic en, pha, pol, wtx, busy, buf_full, load, sclk_st, set_req, rx_valid, tick;
  logic [DIV_W-1:0]  div;
  logic [CHAR_W-1:0] rx_word;
  logic [EDGE_W-1:0] edge_num;

  spi_ctrl_regs #(.CHAR_W(CHAR_W), .DIV_W(DIV_W), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i,
    .ctl_bits_i (wdata_i[2:0]),
    .div_wr_i   (wdata_i[8 +: DIV_W]),
    .busy_i     (busy),
    .buf_full_i (buf_full),
    .set_req_i  (set_req),
    .rx_valid_i (rx_valid),
    .rx_word_i  (rx_word),
    .en_o       (en),
    .pha_o      (pha),
    .pol_o      (pol),
    .div_o      (div),
    .wtx_o      (wtx),
    .tx_req_o,
    .rx_done_o,
    .rdata_o
  );

  spi_baud_gen #(.DIV_W(DIV_W), .EDGES(EDGES), .EDGE_W(EDGE_W)) u_baud (
    .clk_i, .rst_ni,
    .en_i       (en),
    .busy_i     (busy),
    .load_i     (load),
    .div_i      (div),
    .tick_o     (tick),
    .edge_num_o (edge_num)
  );

  spi_shifter #(.CHAR_W(CHAR_W), .EDGE_W(EDGE_W)) u_shift (
    .clk_i, .rst_ni,
    .en_i       (en),
    .pha_i      (pha),
    .wtx_i      (wtx),
    .wdata_i    (wdata_i[CHAR_W-1:0]),
    .miso_i,
    .tick_i     (tick),
    .edge_num_i (edge_num),
    .busy_o     (busy),
    .buf_full_o (buf_full),
    .load_o     (load),
    .sclk_st_o  (sclk_st),
    .mosi_o,
    .set_req_o  (set_req),
    .rx_valid_o (rx_valid),
    .rx_word_o  (rx_word)
  );

  assign sclk_o = pol ^ sclk_st;

  // R5
  idle_write_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && en && !busy) |=> tx_req_o);

  // R10
  disabled_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && $past(!en)) |-> (sclk_o == pol && !mosi_o));
endmodule

// File: tb/spi_tx_master_test.sv
module spi_tx_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, miso = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic sclk, mosi, tx_req, rx_done;

  int checks = 0, errors = 0;
  string scen = "R1";
  bit miso_rnd = 1'b1, miso_fix = 1'b0;

  spi_tx_master uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .tx_req_o(tx_req), .rx_done_o(rx_done)
  );

  always #4 clk = ~clk;

  always @(negedge clk) miso <= miso_rnd ? 1'($urandom % 2) : miso_fix;

  // ---- behavioural reference model ----
  bit m_en, m_pha, m_pol, m_busy, m_sig, m_st, m_req, m_rxdone;
  int m_div, m_cnt, m_edge;
  bit [7:0] m_tx, m_rx, m_rxd;
  bit [7:0] m_q[$];

  task automatic model_step();
    int d = (m_div < 2) ? 2 : m_div;
    bit tick = m_busy && (m_cnt == d - 1);
    int e = m_edge + 1;
    bit lat = tick && (m_pha ? (e % 2 == 0) : (e % 2 == 1));
    bit shf = tick && (m_pha ? (e % 2 == 1 && e >= 3) : (e % 2 == 0 && e <= 14));
    bit fin = tick && (e == 16);
    bit wtx = we && addr == 2'd1;
    bit set_req = 0, set_rx = 0;
    bit old_busy = m_busy;
    int old_n = m_q.size();
    bit [7:0] rx_n;
    if (!m_en) begin
      m_busy = 0; m_q.delete(); m_sig = 0; m_cnt = 0; m_edge = 0; m_st = 0;
    end else begin
      rx_n = lat ? {m_rx[6:0], miso} : m_rx;
      if (tick) begin
        m_cnt = 0; m_edge = e; m_st = !m_st; m_rx = rx_n;
        if (shf) m_tx = m_tx << 1;
      end else if (m_busy) m_cnt++;
      if (fin) begin m_rxd = rx_n; set_rx = 1; m_busy = 0; m_st = 0; end
      if (!old_busy || fin) begin
        if (old_n > 0) begin
          m_tx = m_q.pop_front();
          if (!m_sig) set_req = 1;
          m_sig = 0;
          m_busy = 1; m_cnt = 0; m_edge = 0; m_st = 0;
          if (wtx) begin m_q.push_back(wdata[7:0]); m_sig = 0; end
        end else if (wtx) begin
          m_tx = wdata[7:0]; set_req = 1;
          m_busy = 1; m_cnt = 0; m_edge = 0; m_st = 0;
        end
      end else begin
        if (lat && e == (m_pha ? 16 : 15) && old_n > 0) begin
          set_req = 1; m_sig = 1;
        end
        if (wtx) begin m_q.delete(); m_q.push_back(wdata[7:0]); m_sig = 0; end
      end
    end
    if (set_req) m_req = 1;
    else if (we && addr == 2'd2 && wdata[0]) m_req = 0;
    if (set_rx) m_rxdone = 1;
    else if (we && addr == 2'd2 && wdata[1]) m_rxdone = 0;
    if (we && addr == 2'd0) begin
      m_en = wdata[0]; m_pha = wdata[1]; m_pol = wdata[2]; m_div = int'(wdata[15:8]);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pha = 0; m_pol = 0; m_busy = 0; m_sig = 0; m_st = 0;
      m_req = 0; m_rxdone = 0; m_div = 0; m_cnt = 0; m_edge = 0;
      m_tx = 0; m_rx = 0; m_rxd = 0; m_q.delete();
    end else model_step();
  end

  function automatic logic [15:0] exp_rdata(logic [1:0] a);
    logic [15:0] r = '0;
    case (a)
      2'd0: r = {8'(m_div), 5'd0, m_pol, m_pha, m_en};
      2'd1: r = {12'd0, m_rxdone, m_req, (m_q.size() > 0), m_busy};
      2'd2: r = {8'd0, m_rxd};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    if (rst_n) begin
      #3;
      chk("R2", "sclk", 32'(sclk), 32'(m_pol ^ m_st));
      chk(m_pha ? "R4" : "R3", "mosi", 32'(mosi), 32'(m_busy & m_tx[7]));
      chk(scen, "tx_req", 32'(tx_req), 32'(m_req));
      chk("R9", "rx_done", 32'(rx_done), 32'(m_rxdone));
      chk("R11", "rdata", 32'(rdata), 32'(exp_rdata(addr)));
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd1; wdata = '0;
  endtask

  // counts clocks from the first load (posedge index 0 = write edge)
  task automatic timed_pair(int dv, int last_latch);
    int n;
    wr(2'd1, 16'h00A5);
    chk("R5", "tx_req after idle write", 32'(tx_req), 32'd1);
    wr(2'd2, 16'h0001);
    chk("R8", "tx_req cleared", 32'(tx_req), 32'd0);
    wr(2'd1, 16'h003C);
    n = 2;
    while (!tx_req && n < 400) begin @(negedge clk); n++; end
    chk("R6", "clocks to buffered request", 32'(n), 32'(last_latch * dv));
    while (rdata[0] && n < 600) begin @(negedge clk); n++; end
    chk("R7", "clocks for two characters", 32'(n), 32'(32 * dv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "sclk", 32'(sclk), 0);
    chk("R1", "mosi", 32'(mosi), 0);
    chk("R1", "tx_req", 32'(tx_req), 0);
    chk("R1", "rx_done", 32'(rx_done), 0);
    chk("R1", "ctrl read", 32'(rdata), 0);
    @(negedge clk);

    // phase 0, polarity 0, divider 3
    scen = "R6";
    wr(2'd0, 16'h0301);
    timed_pair(3, 15);
    chk("R9", "rx_done after character", 32'(rx_done), 1);

    // phase 1, polarity 1, divider 1 (clamped to 2), MISO held high
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0107);
    chk("R2", "idle sclk at polarity 1", 32'(sclk), 1);
    miso_fix = 1'b1; miso_rnd = 1'b0;
    timed_pair(2, 16);
    addr = 2'd2; #1;
    chk("R9", "received byte", 32'(rdata), 32'h00FF);
    @(negedge clk);
    wr(2'd2, 16'h0002);
    chk("R9", "rx_done cleared", 32'(rx_done), 0);
    chk("R8", "tx_req kept by rx clear", 32'(tx_req), 1);
    wr(2'd2, 16'h0001);
    chk("R8", "tx_req cleared", 32'(tx_req), 0);
    miso_rnd = 1'b1;

    // disable in mid-character with buffer full
    scen = "R10";
    wr(2'd0, 16'h0401);
    wr(2'd1, 16'h0096);
    wr(2'd1, 16'h0069);
    wr(2'd2, 16'h0001);
    repeat (9) @(negedge clk);
    wr(2'd0, 16'h0400);
    @(negedge clk);
    chk("R10", "status after disable", 32'(rdata), 0);
    chk("R10", "sclk idle", 32'(sclk), 0);
    wr(2'd1, 16'h0077);
    repeat (20) @(negedge clk);
    chk("R10", "status after dropped write", 32'(rdata), 0);
    chk("R10", "no request while disabled", 32'(tx_req), 0);

    // re-enable and run one character
    scen = "R5";
    wr(2'd0, 16'h0503);
    addr = 2'd0; #1;
    chk("R11", "ctrl readback", 32'(rdata), 32'h0503);
    @(negedge clk);
    wr(2'd1, 16'h00C3);
    chk("R5", "tx_req after idle write", 32'(tx_req), 1);
    repeat (100) @(negedge clk);
    chk("R9", "rx_done after phase 1 character", 32'(rx_done), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule